// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs from the oscillator clock, which it divides by four to make the count tick. On that tick it steps a fixed-length conversion through four phases: auto-zero, signal integrate, reference de-integrate and zero-integrate. Each phase drives one one-hot switch-control output. De-integrate has two outputs, one for each reference polarity.

A single comparator input tells the sequencer which side of zero the integrator sits on. The comparator value at the last integrate tick picks the reference polarity that drives the integrator back toward zero. De-integrate time is counted in cascaded BCD decades. The count reached when the comparator flips becomes the reading. If no flip arrives within the full-scale span, the conversion is flagged as overrange.

A zero-integrate phase follows de-integrate to clear any residue on the integrator. Its upper bound is lengthened after an overrange. Auto-zero absorbs whatever time is left, so every conversion has the same total length. The reading, the sign and the overrange flag are updated together, marked by a one-clock load strobe. The comparator is sampled directly on the oscillator clock, so it must already be synchronous to that clock.

Top module: `dsadc_seq`

## Requirements
- R1: Every change of a phase output happens on a count tick, which falls on every fourth oscillator clock edge after reset (edges 4, 8, 12, ...). Every phase therefore lasts a whole number of counts.
- R2: While reset is held, and immediately after it, auto-zero is the active phase, and rd_bcd, rd_neg, rd_ovr and rd_load are all 0. The first signal integrate starts after 3000 counts, at clock edge 12000.
- R3: Exactly one of ph_az, ph_si, ph_dip, ph_din, ph_zi is high at every clock.
- R4: Signal integrate lasts exactly 1000 counts (4000 oscillator clocks).
- R5: The comparator value at the last integrate tick is held for the conversion. A 1 selects ph_dip and a 0 selects ph_din. rd_neg is latched as 1 exactly when that value was 0.
- R6: De-integrate ends at the first tick whose comparator value differs from the held polarity. The reading equals the number of de-integrate ticks before that tick, so de-integrate lasts reading+1 counts.
- R7: If 2000 de-integrate ticks pass without a comparator change, de-integrate ends after 2000 counts. In that case rd_ovr is 1 and the reading is 2000; otherwise rd_ovr is 0.
- R8: rd_bcd holds the reading as BCD: bits 3:0 are units, 7:4 tens, 11:8 hundreds and 15:12 thousands, with thousands limited to 0..2.
- R9: rd_load is high for exactly one oscillator clock per conversion, after de-integrate ends. rd_bcd, rd_neg and rd_ovr change only while rd_load is high.
- R10: Zero-integrate tick j counts from 1. Let c be the first tick whose comparator value differs from the value at the end of de-integrate. Zero-integrate lasts max(c, 11) counts, capped at 140; it lasts 140 if no such change comes.
- R11: After an overrange conversion, the zero-integrate cap is 740 counts instead of 140.
- R12: Auto-zero takes the remaining time, so one conversion from signal-integrate start to the next signal-integrate start is 4000 counts (16000 clocks). The comparator has no effect during auto-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_i | input | 1 | Comparator, 1 when integrator output is above zero; synchronous to clk |
| ph_az | output | 1 | Auto-zero switch control |
| ph_si | output | 1 | Signal integrate switch control |
| ph_dip | output | 1 | De-integrate with positive-input reference polarity |
| ph_din | output | 1 | De-integrate with negative-input reference polarity |
| ph_zi | output | 1 | Zero-integrate switch control |
| rd_bcd | output | 16 | Latched BCD reading |
| rd_neg | output | 1 | Latched negative-input flag |
| rd_ovr | output | 1 | Latched overrange flag |
| rd_load | output | 1 | One-clock strobe marking a new reading |

## Verification
Phase outputs move only on the clock edge that closes a count, so the bench timestamps every phase change by its clock index after reset. It derives each phase length from clock-index differences, expected as four times the count length. The reading, flags and load strobe follow on the clock after the de-integrate exit edge, and the bench checks them at the falling edge where rd_load is seen high. Comparator stimulus from a behavioural integrator is applied at falling edges, so the bench knows exactly which count tick first sees each comparator change.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_AZ = 2'd0,
    PH_SI = 2'd1,
    PH_DI = 2'd2,
    PH_ZI = 2'd3
  } phase_e;

  // Next value of one decade digit that wraps after lim.
  function automatic logic [3:0] dec_next(input logic [3:0] d, input logic [3:0] lim);
    return (d == lim) ? 4'd0 : d + 4'd1;
  endfunction

  // Elaboration-time conversion of a count to eight packed BCD digits.
  function automatic logic [31:0] int_to_bcd(input int val);
    int v;
    logic [31:0] r;
    v = val;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsadc_prediv.sv
module dsadc_prediv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] pre;

  assign tick = (pre == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R1
    end
  endgenerate

endmodule

// File: rtl/dsadc_decades.sv
module dsadc_decades #(
  parameter int NDEC    = 4,
  parameter int TOP_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [NDEC*4-1:0] digits
);
  import dsadc_pkg::*;

  logic [NDEC-1:0] cin;
  assign cin[0] = inc;

  generate
    for (genvar i = 0; i < NDEC; i++) begin : g_dec
      localparam logic [3:0] LIM = (i == NDEC - 1) ? 4'(TOP_MAX) : 4'd9;
      logic [3:0] d;

      always_ff @(posedge clk) begin
        if (!rst_n)      d <= '0;
        else if (clr)    d <= '0;
        else if (cin[i]) begin
          if (i == NDEC - 1 && d == LIM) d <= d;   // top decade saturates
          else                           d <= dec_next(d, LIM);
        end
      end

      if (i < NDEC - 1) begin : g_carry
        assign cin[i+1] = cin[i] & (d == LIM);
      end

      assign digits[i*4 +: 4] = d;

      AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        d <= LIM);  // R8
    end
  endgenerate

endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int SI_CNT = 1000,
  parameter int FULL   = 2000,
  parameter int CYCLE  = 4000,
  parameter int ZI_MIN = 11,
  parameter int ZI_MAX = 140,
  parameter int ZI_OVR = 740,
  parameter int NDEC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmp_i,
  input  logic [NDEC*4-1:0] digits,
  output phase_e            phase,
  output logic              pol_pos,
  output logic              ovr,
  output logic              dec_clr,
  output logic              dec_inc,
  output logic              done_q
);
  localparam int CW = $clog2(CYCLE);
  localparam int ZW = $clog2(ZI_OVR + 1);
  localparam int AZ_LAST = CYCLE - SI_CNT - 1;
  localparam int SI_LAST = CYCLE - 1;
  localparam logic [31:0] LAST32 = int_to_bcd(FULL - 1);
  localparam logic [NDEC*4-1:0] LAST_BCD = LAST32[NDEC*4-1:0];

  logic [CW-1:0] cyc;
  logic [ZW-1:0] zcnt;
  logic [ZW-1:0] zn;
  logic [ZW-1:0] zlim;
  logic          zref;

  // Named phase events
  logic az_end, si_end, di_cross, di_full, di_end, zi_flip, zi_end;

  assign az_end   = (phase == PH_AZ) && (cyc == CW'(AZ_LAST));
  assign si_end   = (phase == PH_SI) && (cyc == CW'(SI_LAST));
  assign di_cross = (phase == PH_DI) && (cmp_i != pol_pos);
  assign di_full  = (phase == PH_DI) && !di_cross && (digits == LAST_BCD);
  assign di_end   = di_cross || di_full;
  assign zn       = zcnt + 1'b1;
  assign zlim     = ovr ? ZW'(ZI_OVR) : ZW'(ZI_MAX);
  assign zi_flip  = (cmp_i != zref);
  assign zi_end   = (phase == PH_ZI) &&
                    ((zi_flip && zn >= ZW'(ZI_MIN)) || zn == zlim);

  assign dec_clr  = tick && si_end;
  assign dec_inc  = tick && (phase == PH_DI) && !di_cross;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_AZ;
      cyc     <= '0;
      zcnt    <= '0;
      zref    <= 1'b0;
      pol_pos <= 1'b0;
      ovr     <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= tick && di_end;
      if (tick) begin
        cyc <= (cyc == CW'(CYCLE - 1)) ? '0 : cyc + 1'b1;
        unique case (phase)
          PH_AZ: if (az_end) phase <= PH_SI;
          PH_SI: if (si_end) begin
            phase   <= PH_DI;
            pol_pos <= cmp_i;
          end
          PH_DI: if (di_end) begin
            phase <= PH_ZI;
            zref  <= cmp_i;
            ovr   <= di_full;
            zcnt  <= '0;
          end
          PH_ZI: begin
            zcnt <= zn;
            if (zi_end) phase <= PH_AZ;
          end
          default: phase <= PH_AZ;
        endcase
      end
    end
  end

  AST_ZI_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AZ && $past(phase) == PH_ZI) |->
      (zcnt >= ZW'(ZI_MIN) && zcnt <= zlim));  // R10
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DI && $past(phase) == PH_DI) |-> $stable(pol_pos));  // R5
  AST_DI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DI) |-> (digits <= LAST_BCD));  // R7
  AST_ZI_BEFORE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ZI) |-> (cyc < CW'(AZ_LAST)));  // R12

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int DIV     = 4,
  parameter int SI_CNT  = 1000,
  parameter int FULL    = 2000,
  parameter int CYCLE   = 4000,
  parameter int ZI_MIN  = 11,
  parameter int ZI_MAX  = 140,
  parameter int ZI_OVR  = 740,
  parameter int NDEC    = 4,
  parameter int TOP_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_i,
  output logic              ph_az,
  output logic              ph_si,
  output logic              ph_dip,
  output logic              ph_din,
  output logic              ph_zi,
  output logic [NDEC*4-1:0] rd_bcd,
  output logic              rd_neg,
  output logic              rd_ovr,
  output logic              rd_load
);
  import dsadc_pkg::*;

  logic              tick;
  logic [NDEC*4-1:0] digits;
  phase_e            phase;
  logic              pol_pos, ovr, dec_clr, dec_inc, done_q;

  dsadc_prediv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  dsadc_decades #(.NDEC(NDEC), .TOP_MAX(TOP_MAX)) u_dec (
    .clk(clk), .rst_n(rst_n), .clr(dec_clr), .inc(dec_inc), .digits(digits)
  );

  dsadc_phase_ctrl #(
    .SI_CNT(SI_CNT), .FULL(FULL), .CYCLE(CYCLE), .ZI_MIN(ZI_MIN),
    .ZI_MAX(ZI_MAX), .ZI_OVR(ZI_OVR), .NDEC(NDEC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_i(cmp_i), .digits(digits),
    .phase(phase), .pol_pos(pol_pos), .ovr(ovr), .dec_clr(dec_clr),
    .dec_inc(dec_inc), .done_q(done_q)
  );

  assign ph_az  = (phase == PH_AZ);
  assign ph_si  = (phase == PH_SI);
  assign ph_dip = (phase == PH_DI) &&  pol_pos;
  assign ph_din = (phase == PH_DI) && !pol_pos;
  assign ph_zi  = (phase == PH_ZI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_bcd  <= '0;
      rd_neg  <= 1'b0;
      rd_ovr  <= 1'b0;
      rd_load <= 1'b0;
    end else begin
      rd_load <= done_q;
      if (done_q) begin
        rd_bcd <= digits;
        rd_neg <= !pol_pos;
        rd_ovr <= ovr;
      end
    end
  end

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ph_az, ph_si, ph_dip, ph_din, ph_zi}) == 1);  // R3
  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({ph_az, ph_si, ph_dip, ph_din, ph_zi}));  // R1
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> !rd_load);  // R9

endmodule

// File: tb/sim_dsadc_seq.sv
module sim_dsadc_seq;
  localparam int NCONV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0;
  logic ph_az, ph_si, ph_dip, ph_din, ph_zi, rd_neg, rd_ovr, rd_load;
  logic [15:0] rd_bcd;

  always #10 clk = ~clk;

  dsadc_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp),
    .ph_az(ph_az), .ph_si(ph_si), .ph_dip(ph_dip), .ph_din(ph_din), .ph_zi(ph_zi),
    .rd_bcd(rd_bcd), .rd_neg(rd_neg), .rd_ovr(rd_ovr), .rd_load(rd_load)
  );

  int total = 0, bad = 0;
  int v8_tab[NCONV], zc_tab[NCONV];
  int e_rd[NCONV], e_k[NCONV], e_zl[NCONV];
  bit e_neg[NCONV], e_ovr[NCONV];

  int pcnt = 0;
  int integ = 0, v8_act = 0, zc_act = 0, zn = 0;
  bit zentry = 1'b0;
  int t_si = 0, t_di = 0, t_zi = 0, t_az = 0;
  int cidx = -1, loads = 0, onehot_bad = 0, hold_bad = 0;
  bit done = 1'b0;
  logic [4:0] prev_ph = 5'b10000;
  logic [15:0] prev_bcd = '0;
  logic prev_neg = 1'b0, prev_ovr = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] exp_bcd(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  // Stimulus in eighths of a count; expectations derived from the requirements.
  task automatic plan_conv(input int i, input int v8, input int zc);
    int mag, n, lim;
    v8_tab[i] = v8;
    zc_tab[i] = zc;
    mag = (v8 < 0) ? -v8 : v8;
    n = mag / 8;
    e_neg[i] = (v8 < 0);
    e_ovr[i] = (n >= 2000);
    e_rd[i] = e_ovr[i] ? 2000 : n;
    e_k[i] = e_ovr[i] ? 2000 : n + 1;
    lim = e_ovr[i] ? 740 : 140;
    if (zc == 0 || zc > lim) e_zl[i] = lim;
    else if (zc < 11)        e_zl[i] = 11;
    else                     e_zl[i] = zc;
  endtask

  always @(posedge clk) if (rst_n) pcnt <= pcnt + 1;

  always @(negedge clk) begin
    logic [4:0] ph;
    if (rst_n && !done) begin
      ph = {ph_az, ph_si, ph_dip, ph_din, ph_zi};
      if ($countones(ph) != 1) onehot_bad++;
      if (!rd_load && (rd_bcd != prev_bcd || rd_neg != prev_neg || rd_ovr != prev_ovr))
        hold_bad++;
      prev_bcd = rd_bcd; prev_neg = rd_neg; prev_ovr = rd_ovr;

      if (ph != prev_ph) begin
        check(pcnt % 4 == 0, "R1", "phase change clock index mod 4", pcnt % 4, 0);
        if (ph_si) begin
          if (cidx < 0) check(pcnt == 12000, "R2", "first integrate start", pcnt, 12000);
          else begin
            check(pcnt - t_az == 4 * (3000 - e_k[cidx] - e_zl[cidx]), "R12",
                  "auto-zero length", pcnt - t_az, 4 * (3000 - e_k[cidx] - e_zl[cidx]));
            check(pcnt - t_si == 16000, "R12", "conversion length", pcnt - t_si, 16000);
            check(loads == 1, "R9", "load strobes per conversion", loads, 1);
          end
          cidx++;
          t_si = pcnt;
          loads = 0;
          if (cidx == NCONV) done = 1'b1;
          else begin
            v8_act = v8_tab[cidx];
            zc_act = zc_tab[cidx];
            integ = 0;
          end
        end else if (ph_dip || ph_din) begin
          check(pcnt - t_si == 4000, "R4", "integrate length", pcnt - t_si, 4000);
          check(ph_dip == !e_neg[cidx], "R5", "reference polarity dip", ph_dip, !e_neg[cidx]);
          t_di = pcnt;
        end else if (ph_zi) begin
          check(pcnt - t_di == 4 * e_k[cidx], e_ovr[cidx] ? "R7" : "R6",
                "de-integrate length", pcnt - t_di, 4 * e_k[cidx]);
          t_zi = pcnt;
          zn = 0;
          zentry = cmp;
        end else if (ph_az) begin
          check(pcnt - t_zi == 4 * e_zl[cidx], e_ovr[cidx] ? "R11" : "R10",
                "zero-integrate length", pcnt - t_zi, 4 * e_zl[cidx]);
          t_az = pcnt;
        end
      end
      prev_ph = ph;

      if (rd_load && cidx >= 0 && cidx < NCONV) begin
        loads++;
        check(rd_bcd == exp_bcd(e_rd[cidx]), "R8", "reading R6", rd_bcd, exp_bcd(e_rd[cidx]));
        check(rd_neg == e_neg[cidx], "R5", "negative flag", rd_neg, e_neg[cidx]);
        check(rd_ovr == e_ovr[cidx], "R7", "overrange flag", rd_ovr, e_ovr[cidx]);
      end

      // Behavioural integrator and comparator
      if (!done) begin
        if (ph_si) begin
          integ += v8_act; cmp = (integ > 0);
        end else if (ph_dip) begin
          integ -= 8000; cmp = (integ > 0);
        end else if (ph_din) begin
          integ += 8000; cmp = (integ > 0);
        end else if (ph_zi) begin
          if (zc_act != 0 && zn == 4 * (zc_act - 1)) cmp = !zentry;
          zn++;
        end else begin
          cmp = 1'($urandom % 2);   // R12: ignored in auto-zero
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd7136));
    plan_conv(0, 4, 5);
    plan_conv(1, -4, 0);
    plan_conv(2, 8 * 123 + 4, 60);
    plan_conv(3, -(8 * 1999 + 4), 200);
    plan_conv(4, 8 * 2000 + 4, 300);
    plan_conv(5, -(8 * 2500 + 3), 0);
    for (int i = 6; i < NCONV; i++) begin
      int n, fr, v;
      n = int'($urandom % 2300);
      fr = 1 + int'($urandom % 7);
      v = 8 * n + fr;
      if ($urandom % 2 == 1) v = -v;
      plan_conv(i, v, int'($urandom % 760));
    end

    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(ph_az && !ph_si && !ph_dip && !ph_din && !ph_zi, "R2", "reset phase az",
          {ph_az, ph_si, ph_dip, ph_din, ph_zi}, 5'b10000);
    check(rd_bcd == 16'h0 && !rd_neg && !rd_ovr && !rd_load, "R2", "reset outputs",
          {rd_bcd, rd_neg, rd_ovr, rd_load}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ph_az == 1'b1, "R2", "auto-zero after reset", ph_az, 1);

    while (!done && pcnt < 190000) @(negedge clk);
    if (!done) check(1'b0, "R12", "watchdog expired", pcnt, 190000);
    check(onehot_bad == 0, "R3", "one-hot violations", onehot_bad, 0);
    check(hold_bad == 0, "R9", "outputs changed without strobe", hold_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule